// File: doc/BRIEF.md
# SPI NOR flash command and status core

This block is the command-decoding core of a serial NOR flash device. It sits behind a byte deserializer. Each byte it accepts arrives with a valid strobe while chip select is active. The block decodes opcodes and keeps the status register. That register holds the write-enable latch, the status-lock bit and the protection field. The block also tracks whether addresses are three or four bytes long, and it answers identification and status reads on a byte output.

Array operations are not performed here. The block issues single-cycle grant strobes with an address to a storage model: one for each program byte, one for each read byte, one for a sector erase and one for a whole-chip erase. Several commands may be chained inside one chip-select frame. A new opcode is decoded as soon as the previous command has consumed its bytes.

Top module: `spi_flash_cmd_unit`

## Requirements
- R1: After reset the status register reads 0x00, addr4_o is 0, rdata_o is 0x00 and no grant strobe is active.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch is status bit 1. Opcode 0x05 places the status byte on rdata_o in the cycle after the opcode is accepted, then consumes one further byte.
- R3: Opcode 0x01 followed by one data byte writes status bits 7:2 from that byte. The write happens only if the latch is set and the pair (wp_ni low, status bit 7 set) does not hold. Bits 1:0 are never written. Once the data byte is consumed the latch is cleared, whether the write happened or not.
- R4: Opcode 0x9F puts 0x20 on rdata_o, and the next two accepted bytes bring 0xBA and then 0x19. The third byte after the opcode sets rdata_o to 0x00, and decoding then resumes.
- R5: Opcode 0xB7 sets addr4_o. Addresses are then taken as four bytes, otherwise three, most significant byte first.
- R6: Opcode 0x03: after the address, every accepted byte pulses read_o with addr_o. addr_o starts at the address and counts up by one across the full width.
- R7: Opcode 0x02: after the address, every accepted byte pulses prog_o with the byte on wdata_o and the address on addr_o. The address then increments, wrapping inside a 2^PAGE_W byte page. Pulses occur only if the latch was set at the opcode. Chip-select release ends a granted program and clears the latch.
- R8: Opcode 0xD8 with the latch set pulses sector_erase_o with the assembled address on addr_o when the last address byte is accepted, and clears the latch. Without the latch set, no pulse occurs.
- R9: Opcode 0xC7 with the latch set pulses chip_erase_o and clears the latch. Without the latch set, nothing happens.
- R10: Opcode 0x99 accepted as the opcode directly after 0x66 clears the latch and addr4_o, and leaves status bits 7:2 unchanged. Opcode 0x99 without a preceding 0x66 is treated as unknown.
- R11: After an unknown opcode the rest of the frame is ignored. Decoding restarts when chip select is released.
- R12: Commands chained within one frame are each decoded once the previous one has consumed its bytes.
- R13: Grant strobes are single-cycle, at most one at a time, and only appear in the cycle after a byte accepted with chip select active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_active_i | input | 1 | Chip select asserted (frame open) |
| byte_valid_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Received byte |
| wp_ni | input | 1 | Write-protect pin, active low |
| rdata_o | output | 8 | Status or identification byte for the host |
| addr4_o | output | 1 | Four-byte address mode |
| read_o | output | 1 | Read grant to storage |
| prog_o | output | 1 | Program grant to storage |
| sector_erase_o | output | 1 | Sector erase grant |
| chip_erase_o | output | 1 | Whole-chip erase grant |
| addr_o | output | ADDR_W | Address for the current grant |
| wdata_o | output | 8 | Program data byte |

## Verification
The hardest case to reach is the status-write lock: status bit 7 must already be set while wp_ni is high, and only then is wp_ni pulled low before a latched write attempts to clear it. The stimulus first sets the lock bit with the pin high, then lowers the pin and retries, and reads the status back in a separate frame. A second hard case is the page wrap during program, reached by starting a program two bytes below a page boundary. A third is the reset pair, checked both as a proper 0x66/0x99 sequence and as a lone 0x99.

// File: rtl/spi_flash_cmd_pkg.sv
package spi_flash_cmd_pkg;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RSTEN  = 8'h66;
  localparam logic [7:0] OP_RSTMEM = 8'h99;
  localparam logic [7:0] OP_RDID   = 8'h9F;
  localparam logic [7:0] OP_EN4B   = 8'hB7;
  localparam logic [7:0] OP_CHIP   = 8'hC7;
  localparam logic [7:0] OP_SECT   = 8'hD8;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_STAT, ST_ID, ST_WRSR, ST_READ, ST_PROG, ST_SKIP
  } st_e;

  typedef enum logic [1:0] {
    CMD_READ, CMD_PROG, CMD_ERASE
  } cmd_e;
endpackage

// File: rtl/spi_flash_status_reg.sv
module spi_flash_status_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_wel_i,
  input  logic       clr_wel_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  input  logic       wp_ni,
  output logic [7:0] status_o,
  output logic       wel_o
);
  logic [5:0] prot_q;
  logic       wel_q;
  logic       locked;

  // lock bit plus pin low blocks the write
  assign locked = !wp_ni && prot_q[5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= '0;
      wel_q  <= 1'b0;
    end else begin
      if (wr_i && wel_q && !locked) prot_q <= wr_data_i[7:2];
      if (clr_wel_i)      wel_q <= 1'b0;
      else if (set_wel_i) wel_q <= 1'b1;
    end
  end

  assign status_o = {prot_q, wel_q, 1'b0};
  assign wel_o    = wel_q;
endmodule

// File: rtl/spi_flash_addr_acc.sv
module spi_flash_addr_acc #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic [7:0]        byte_i,
  input  logic              inc_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [PAGE_W-1:0] P_ONE = PAGE_W'(1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (clr_i) begin
      addr_q <= '0;
    end else if (shift_i) begin
      addr_q <= {addr_q[ADDR_W-9:0], byte_i};
    end else if (inc_i) begin
      if (wrap_i) addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + P_ONE;
      else        addr_q <= addr_q + A_ONE;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/spi_flash_cmd_unit.sv
module spi_flash_cmd_unit
  import spi_flash_cmd_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          PAGE_W  = 8,
  parameter logic [23:0] ID_CODE = 24'h20BA19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              wp_ni,
  output logic [7:0]        rdata_o,
  output logic              addr4_o,
  output logic              read_o,
  output logic              prog_o,
  output logic              sector_erase_o,
  output logic              chip_erase_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o
);
  localparam logic [2:0] LAST3 = 3'd2;
  localparam logic [2:0] LAST4 = 3'd3;

  st_e  st_q;
  cmd_e cmd_q;
  logic [2:0] cnt_q;
  logic grant_q, armed_q, addr4_q;

  logic acc, last;
  logic set_wel, clr_wel, wr_st;
  logic a_clr, a_shift, a_inc, a_wrap;
  logic [7:0] status;
  logic wel;
  logic [ADDR_W-1:0] acc_addr, shifted;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = ID_CODE[23:16];
      3'd1:    id_byte = ID_CODE[15:8];
      3'd2:    id_byte = ID_CODE[7:0];
      default: id_byte = 8'h00;
    endcase
  endfunction

  assign acc     = cs_active_i && byte_valid_i;
  assign last    = cnt_q == (addr4_q ? LAST4 : LAST3);
  assign shifted = {acc_addr[ADDR_W-9:0], byte_i};

  spi_flash_status_reg i_status (
    .clk_i, .rst_ni,
    .set_wel_i (set_wel),
    .clr_wel_i (clr_wel),
    .wr_i      (wr_st),
    .wr_data_i (byte_i),
    .wp_ni,
    .status_o  (status),
    .wel_o     (wel)
  );

  spi_flash_addr_acc #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_addr (
    .clk_i, .rst_ni,
    .clr_i   (a_clr),
    .shift_i (a_shift),
    .byte_i,
    .inc_i   (a_inc),
    .wrap_i  (a_wrap),
    .addr_o  (acc_addr)
  );

  always_comb begin
    set_wel = 1'b0; clr_wel = 1'b0; wr_st = 1'b0;
    a_clr = 1'b0; a_shift = 1'b0; a_inc = 1'b0; a_wrap = 1'b0;
    if (!cs_active_i) begin
      if (st_q == ST_PROG && grant_q) clr_wel = 1'b1;
    end else if (acc) begin
      case (st_q)
        ST_OPC: begin
          case (byte_i)
            OP_WREN:   set_wel = 1'b1;
            OP_WRDI:   clr_wel = 1'b1;
            OP_CHIP:   clr_wel = 1'b1;
            OP_RSTMEM: clr_wel = armed_q;
            OP_READ, OP_PROG, OP_SECT: a_clr = 1'b1;
            default: ;
          endcase
        end
        ST_ADDR: begin
          a_shift = 1'b1;
          if (last && cmd_q == CMD_ERASE && grant_q) clr_wel = 1'b1;
        end
        ST_WRSR: begin
          wr_st   = 1'b1;
          clr_wel = 1'b1;
        end
        ST_READ: a_inc = 1'b1;
        ST_PROG: begin
          a_inc  = grant_q;
          a_wrap = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OPC; cmd_q <= CMD_READ; cnt_q <= '0;
      grant_q <= 1'b0; armed_q <= 1'b0; addr4_q <= 1'b0;
      rdata_o <= '0; addr_o <= '0; wdata_o <= '0;
      read_o <= 1'b0; prog_o <= 1'b0;
      sector_erase_o <= 1'b0; chip_erase_o <= 1'b0;
    end else begin
      read_o <= 1'b0; prog_o <= 1'b0;
      sector_erase_o <= 1'b0; chip_erase_o <= 1'b0;
      if (!cs_active_i) begin
        st_q  <= ST_OPC;
        cnt_q <= '0;
      end else if (acc) begin
        case (st_q)
          ST_OPC: begin
            armed_q <= (byte_i == OP_RSTEN);
            case (byte_i)
              OP_WREN, OP_WRDI, OP_RSTEN: ;
              OP_RDSR: begin rdata_o <= status; st_q <= ST_STAT; end
              OP_RDID: begin rdata_o <= id_byte(3'd0); cnt_q <= '0; st_q <= ST_ID; end
              OP_WRSR: st_q <= ST_WRSR;
              OP_EN4B: addr4_q <= 1'b1;
              OP_CHIP: chip_erase_o <= wel;
              OP_RSTMEM: begin
                if (armed_q) addr4_q <= 1'b0;
                else         st_q <= ST_SKIP;
              end
              OP_READ: begin cmd_q <= CMD_READ;  grant_q <= 1'b1; cnt_q <= '0; st_q <= ST_ADDR; end
              OP_PROG: begin cmd_q <= CMD_PROG;  grant_q <= wel;  cnt_q <= '0; st_q <= ST_ADDR; end
              OP_SECT: begin cmd_q <= CMD_ERASE; grant_q <= wel;  cnt_q <= '0; st_q <= ST_ADDR; end
              default: st_q <= ST_SKIP;
            endcase
          end
          ST_STAT: st_q <= ST_OPC;
          ST_ID: begin
            rdata_o <= id_byte(cnt_q + 3'd1);
            cnt_q   <= cnt_q + 3'd1;
            if (cnt_q == 3'd2) st_q <= ST_OPC;
          end
          ST_ADDR: begin
            cnt_q <= cnt_q + 3'd1;
            if (last) begin
              case (cmd_q)
                CMD_READ: st_q <= ST_READ;
                CMD_PROG: st_q <= ST_PROG;
                default: begin
                  if (grant_q) begin
                    sector_erase_o <= 1'b1;
                    addr_o         <= shifted;
                  end
                  st_q <= ST_OPC;
                end
              endcase
            end
          end
          ST_READ: begin
            read_o <= 1'b1;
            addr_o <= acc_addr;
          end
          ST_PROG: begin
            if (grant_q) begin
              prog_o  <= 1'b1;
              wdata_o <= byte_i;
              addr_o  <= acc_addr;
            end
          end
          ST_WRSR: st_q <= ST_OPC;
          default: ;
        endcase
      end
    end
  end

  assign addr4_o = addr4_q;
endmodule

// File: rtl/spi_flash_cmd_unit_chk.sv
module spi_flash_cmd_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_active_i,
  input logic byte_valid_i,
  input logic wp_ni,
  input logic read_o,
  input logic prog_o,
  input logic sector_erase_o,
  input logic chip_erase_o,
  input logic wel_i,
  input logic srwd_i
);
  logic any_grant;
  assign any_grant = read_o || prog_o || sector_erase_o || chip_erase_o;

  assert_one_grant_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({read_o, prog_o, sector_erase_o, chip_erase_o}));

  assert_grant_after_byte_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_grant |-> $past(cs_active_i && byte_valid_i));

  assert_prog_needs_wel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> $past(wel_i));

  assert_sector_needs_wel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_erase_o |-> $past(wel_i));

  assert_chip_needs_wel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_o |-> $past(wel_i));

  assert_wp_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!wp_ni) && $past(srwd_i)) |-> srwd_i);
endmodule

bind spi_flash_cmd_unit spi_flash_cmd_unit_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cs_active_i    (cs_active_i),
  .byte_valid_i   (byte_valid_i),
  .wp_ni          (wp_ni),
  .read_o         (read_o),
  .prog_o         (prog_o),
  .sector_erase_o (sector_erase_o),
  .chip_erase_o   (chip_erase_o),
  .wel_i          (wel),
  .srwd_i         (status[7])
);

// File: tb/test_spi_flash_cmd_unit.sv
module test_spi_flash_cmd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int WD_CYCLES = 100000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs = 1'b0, bv = 1'b0, wp_n = 1'b1;
  logic [7:0] bt = 8'h00;
  logic [7:0] rdata;
  logic addr4, rd_g, pg_g, se_g, ce_g;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_flash_cmd_unit i_spi_flash_cmd_unit (
    .clk_i, .rst_ni,
    .cs_active_i (cs), .byte_valid_i (bv), .byte_i (bt), .wp_ni (wp_n),
    .rdata_o (rdata), .addr4_o (addr4),
    .read_o (rd_g), .prog_o (pg_g), .sector_erase_o (se_g), .chip_erase_o (ce_g),
    .addr_o (addr), .wdata_o (wdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_grants(input string tag, input logic [3:0] exp);
    check(tag, {28'h0, rd_g, pg_g, se_g, ce_g}, {28'h0, exp});
  endtask

  task automatic fstart;
    @(negedge clk_i); cs = 1'b1;
  endtask
  task automatic fend;
    @(negedge clk_i); cs = 1'b0; @(negedge clk_i);
  endtask
  task automatic send(input logic [7:0] b);
    @(negedge clk_i); bv = 1'b1; bt = b;
    @(negedge clk_i); bv = 1'b0;
  endtask
  task automatic cmd1(input logic [7:0] b);
    fstart; send(b); fend;
  endtask
  task automatic rd_status(output logic [7:0] s);
    fstart; send(8'h05); s = rdata; send(8'h00); fend;
  endtask
  task automatic wr_status(input logic [7:0] v);
    fstart; send(8'h06); send(8'h01); send(v); fend;
  endtask

  task automatic t_reset;
    logic [7:0] s;
    check("R1 rdata", {24'h0, rdata}, 32'h0);
    check("R1 addr4", {31'h0, addr4}, 32'h0);
    check_grants("R1 grants", 4'b0000);
    rd_status(s); check("R1 status", {24'h0, s}, 32'h00);
  endtask

  task automatic t_wel;
    logic [7:0] s;
    cmd1(8'h06); rd_status(s); check("R2 wel set", {24'h0, s}, 32'h02);
    cmd1(8'h04); rd_status(s); check("R2 wel clr", {24'h0, s}, 32'h00);
    fstart;
    send(8'h06); send(8'h05); check("R12 chain wren", {24'h0, rdata}, 32'h02);
    send(8'h00); send(8'h04); send(8'h05); check("R12 chain wrdi", {24'h0, rdata}, 32'h00);
    send(8'h00);
    fend;
  endtask

  task automatic t_id;
    fstart;
    send(8'h9F); check("R4 id0", {24'h0, rdata}, 32'h20);
    send(8'h00); check("R4 id1", {24'h0, rdata}, 32'hBA);
    send(8'h00); check("R4 id2", {24'h0, rdata}, 32'h19);
    send(8'h00); check("R4 id end", {24'h0, rdata}, 32'h00);
    send(8'h05); check("R4 resume", {24'h0, rdata}, 32'h00);
    send(8'h00);
    fend;
  endtask

  task automatic t_wrsr;
    logic [7:0] s;
    wp_n = 1'b1; wr_status(8'h80); rd_status(s); check("R3 set lock", {24'h0, s}, 32'h80);
    wp_n = 1'b0; wr_status(8'h00); rd_status(s); check("R3 locked", {24'h0, s}, 32'h80);
    wp_n = 1'b1; wr_status(8'h00); rd_status(s); check("R3 pin high", {24'h0, s}, 32'h00);
    wp_n = 1'b0; wr_status(8'h9C); rd_status(s); check("R3 lock clear pin low", {24'h0, s}, 32'h9C);
    fstart; send(8'h01); send(8'h00); fend;
    rd_status(s); check("R3 no wel", {24'h0, s}, 32'h9C);
    wp_n = 1'b1; wr_status(8'h03); rd_status(s); check("R3 low bits", {24'h0, s}, 32'h00);
  endtask

  task automatic t_read;
    fstart;
    send(8'h03); send(8'h12); send(8'h34); check_grants("R13 no grant in addr", 4'b0000);
    send(8'h56); check_grants("R6 none at last addr", 4'b0000);
    send(8'h00); check_grants("R6 rd0", 4'b1000); check("R6 a0", addr, 32'h00123456);
    send(8'h00); check("R6 a1", addr, 32'h00123457);
    send(8'h00); check("R6 a2", addr, 32'h00123458);
    fend;
    check_grants("R13 idle", 4'b0000);
  endtask

  task automatic t_4b;
    cmd1(8'hB7); check("R5 addr4", {31'h0, addr4}, 32'h1);
    fstart;
    send(8'h03); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
    send(8'h00); check_grants("R5 rd", 4'b1000); check("R5 a4", addr, 32'h01020304);
    fend;
  endtask

  task automatic t_prog;
    logic [7:0] s;
    cmd1(8'h06);
    fstart;
    send(8'h02); send(8'h00); send(8'h00); send(8'h01); send(8'hFE);
    check_grants("R7 none in addr", 4'b0000);
    send(8'hAA); check_grants("R7 p0", 4'b0100);
    check("R7 a0", addr, 32'h1FE); check("R7 d0", {24'h0, wdata}, 32'hAA);
    send(8'hBB); check("R7 a1", addr, 32'h1FF);
    send(8'hCC); check("R7 wrap", addr, 32'h100); check("R7 d2", {24'h0, wdata}, 32'hCC);
    fend;
    rd_status(s); check("R7 wel cleared", {24'h0, s}, 32'h00);
    fstart;
    send(8'h02); send(8'h00); send(8'h00); send(8'h02); send(8'h00);
    send(8'h55); check_grants("R7 no wel", 4'b0000);
    fend;
  endtask

  task automatic t_erase;
    fstart;
    send(8'h06); send(8'hD8); send(8'h00); send(8'h12); send(8'h34);
    check_grants("R8 none early", 4'b0000);
    send(8'h56); check_grants("R8 erase", 4'b0010); check("R8 addr", addr, 32'h00123456);
    send(8'h05); check("R12 wel after erase", {24'h0, rdata}, 32'h00);
    send(8'h00);
    fend;
    fstart;
    send(8'hD8); send(8'h00); send(8'h00); send(8'h00);
    send(8'h00); check_grants("R8 no wel", 4'b0000);
    fend;
  endtask

  task automatic t_chip;
    logic [7:0] s;
    fstart; send(8'h06); send(8'hC7); check_grants("R9 chip", 4'b0001); fend;
    rd_status(s); check("R9 wel cleared", {24'h0, s}, 32'h00);
    fstart; send(8'hC7); check_grants("R9 no wel", 4'b0000); fend;
  endtask

  task automatic t_swreset;
    logic [7:0] s;
    wp_n = 1'b1; wr_status(8'h3C);
    cmd1(8'h06); rd_status(s); check("R10 pre", {24'h0, s}, 32'h3E);
    fstart; send(8'h66); send(8'h99); fend;
    check("R10 addr4 cleared", {31'h0, addr4}, 32'h0);
    rd_status(s); check("R10 keeps prot", {24'h0, s}, 32'h3C);
    cmd1(8'hB7); cmd1(8'h06); cmd1(8'h99);
    check("R10 lone 99 addr4", {31'h0, addr4}, 32'h1);
    rd_status(s); check("R10 lone 99 wel", {24'h0, s}, 32'h3E);
    wr_status(8'h00);
  endtask

  task automatic t_unknown;
    logic [7:0] s;
    fstart; send(8'hAB); send(8'h06); send(8'hC7);
    check_grants("R11 skipped", 4'b0000); fend;
    rd_status(s); check("R11 wel untouched", {24'h0, s}, 32'h00);
    fstart; send(8'h99); send(8'h06); fend;
    rd_status(s); check("R11 skip after 99", {24'h0, s}, 32'h00);
    fstart; send(8'h06); send(8'hC7); check_grants("R11 resumed", 4'b0001); fend;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_wel;
    t_id;
    t_wrsr;
    t_read;
    t_4b;
    t_prog;
    t_erase;
    t_chip;
    t_swreset;
    t_unknown;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule